// File: doc/BRIEF.md
# Redirection-Entry Interrupt Delivery Engine

This block watches a bank of interrupt input pins and turns their requests into message-signalled interrupt writes. Each write is a 32-bit address and a 32-bit data word presented on a valid/ready output port. Every pin has a 64-bit redirection entry, which arrives as one flat input bus from the register block that owns it. That entry sets the pin's vector, delivery mode, destination, destination mode, trigger mode and mask.

The block owns two pieces of per-pin state: a request bit and a remote-IRR bit. The remote-IRR bit is returned on its own output so the register block can show it. Level pins stay blocked after delivery until an end-of-interrupt (EOI) carrying their vector arrives. They then fire again if the pin is still asserted.

Pins pass through a synchroniser. A single scan pointer then visits the pins one at a time. It launches at most one message for each step, and it stops advancing while the output slot is held.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset, `msgValid` is 0 and every `remoteIrr` bit is 0.
- R2: A level pin (entry bit 15 = 1) has its request follow the synchronised pin. While the pin is high, unmasked (bit 16 = 0) and its remote IRR is clear, it is delivered once, and remote IRR is set in the same cycle the message becomes valid.
- R3: On an edge pin (bit 15 = 0), a rising edge that arrives while bit 16 = 1 is discarded. Clearing the mask later produces no message.
- R4: Each rising edge on an unmasked edge pin yields exactly one message. The request is cleared at launch, unless a new edge lands in that same cycle.
- R5: A level pin whose remote IRR is set sends nothing further, however long it stays high.
- R6: An EOI with vector V clears remote IRR on every level entry that has remote IRR set and vector bits 7:0 equal to V. Other entries keep theirs. A cleared entry that is still requested and unmasked is delivered again.
- R7: The message address is 0xFEE00000 with the destination (entry bits 63:48) at address bits 19:4 and the destination mode (entry bit 11) at address bit 2.
- R8: The message data has the vector (entry bits 7:0) in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8 and the trigger mode in bit 15. All other bits are zero.
- R9: The pins are visited in ascending order from pin 0, wrapping at the last pin, one pin per cycle while the slot is free. While `msgValid` is high and `msgReady` is low, the scan holds and the address and data stay stable.
- R10: While an entry selects edge mode, its remote IRR is 0 from the next cycle on. Entry bit 14 on the input is ignored.
- R11: A masked level pin keeps its request but is not delivered. It is delivered after its mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPins | input | NUM_PINS | Raw interrupt input pins |
| rteFlat | input | NUM_PINS*64 | Redirection entries, pin p at bits p*64 +: 64 |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector carried by the EOI |
| msgValid | output | 1 | Message write pending |
| msgReady | input | 1 | Consumer accepts the message |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |
| remoteIrr | output | NUM_PINS | Per-pin remote-IRR state |

## Verification
Two functions can collide in one cycle.

- **EOI against launch.** An EOI can clear remote IRR on one pin while the scan launches another. The bench provokes this with EOIs whose vectors match several level pins, plus random backpressure.
- **New edge against launch.** A new edge can set a pin's request in the very cycle the scan clears that request at launch. The bench provokes this by pulsing edge pins at random during a long mixed phase.

A behavioural per-pin reference model in the bench predicts `msgValid`, the address, the data and every remote-IRR bit on each clock. A lost or doubled request therefore shows up as a mismatch.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int ENTRY_W      = 64;
  localparam int VEC_LSB      = 0;
  localparam int DMODE_LSB    = 8;
  localparam int DESTMODE_BIT = 11;
  localparam int TRIG_BIT     = 15;
  localparam int MASK_BIT     = 16;
  localparam int DEST_LSB     = 48;
  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;

  typedef struct packed {
    logic launch;   // load the output slot from the pin under the pointer
    logic advance;  // step the scan pointer
  } ctlStrobe_t;

  function automatic logic [7:0] vecOf(input logic [ENTRY_W-1:0] e);
    return e[VEC_LSB +: 8];
  endfunction

  function automatic logic trigOf(input logic [ENTRY_W-1:0] e);
    return e[TRIG_BIT];
  endfunction

  function automatic logic maskOf(input logic [ENTRY_W-1:0] e);
    return e[MASK_BIT];
  endfunction

  function automatic logic [31:0] msgAddrOf(input logic [ENTRY_W-1:0] e);
    logic [31:0] a;
    a = MSG_BASE;
    a[19:4] = e[DEST_LSB +: 16];
    a[2]    = e[DESTMODE_BIT];
    return a;
  endfunction

  function automatic logic [31:0] msgDataOf(input logic [ENTRY_W-1:0] e);
    logic [31:0] d;
    d = '0;
    d[7:0]  = e[VEC_LSB +: 8];
    d[10:8] = e[DMODE_LSB +: 3];
    d[15]   = e[TRIG_BIT];
    return d;
  endfunction

endpackage

// File: rtl/irq_redir_datapath.sv
module irq_redir_datapath
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_PINS-1:0]      irqPins,
  input  logic [NUM_PINS*64-1:0]   rteFlat,
  input  logic                     eoiValid,
  input  logic [7:0]               eoiVector,
  input  logic                     msgReady,
  input  ctlStrobe_t               strobe,
  input  logic [PTR_W-1:0]         ptr,
  output logic [NUM_PINS-1:0]      eligible,
  output logic                     msgValid,
  output logic [31:0]              msgAddr,
  output logic [31:0]              msgData,
  output logic [NUM_PINS-1:0]      remoteIrr
);

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinPrevQ;
  logic [NUM_PINS-1:0] irrQ;
  logic [NUM_PINS-1:0] remoteIrrQ;
  logic [NUM_PINS-1:0] pinLevel;
  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_PINS-1:0] trigLevel;
  logic [NUM_PINS-1:0] pinMask;
  logic [ENTRY_W-1:0]  selEntry;
  logic                msgValidQ;
  logic [31:0]         msgAddrQ;
  logic [31:0]         msgDataQ;

  // input synchroniser chain
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= irqPins;
  end

  generate
    for (genvar k = 1; k < SYNC_STAGES; k++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[k] <= '0;
        else       syncQ[k] <= syncQ[k-1];
      end
    end
  endgenerate

  assign pinLevel = syncQ[SYNC_STAGES-1];
  assign pinRise  = pinLevel & ~pinPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) pinPrevQ <= '0;
    else       pinPrevQ <= pinLevel;
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
      logic [ENTRY_W-1:0] ent;
      logic               hit;
      assign ent          = rteFlat[p*ENTRY_W +: ENTRY_W];
      assign trigLevel[p] = trigOf(ent);
      assign pinMask[p]   = maskOf(ent);
      assign hit          = strobe.launch && (ptr == PTR_W'(p));
      assign eligible[p]  = irrQ[p] && !pinMask[p] && (!trigLevel[p] || !remoteIrrQ[p]);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          irrQ[p]       <= 1'b0;
          remoteIrrQ[p] <= 1'b0;
        end else begin
          if (trigLevel[p])                  irrQ[p] <= pinLevel[p];
          else if (pinRise[p] && !pinMask[p]) irrQ[p] <= 1'b1;
          else if (hit)                       irrQ[p] <= 1'b0;

          if (!trigLevel[p])                  remoteIrrQ[p] <= 1'b0;
          else if (eoiValid && remoteIrrQ[p] && vecOf(ent) == eoiVector)
                                              remoteIrrQ[p] <= 1'b0;
          else if (hit)                       remoteIrrQ[p] <= 1'b1;
        end
      end

      AST_EDGE_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rstN)
        !trigLevel[p] |=> !remoteIrrQ[p]); // R10
      AST_EOI_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rstN)
        (eoiValid && trigLevel[p] && remoteIrrQ[p] && vecOf(ent) == eoiVector) |=> !remoteIrrQ[p]); // R6
      AST_RIRR_WITH_MSG: assert property (@(posedge clk) disable iff (!rstN)
        $rose(remoteIrrQ[p]) |-> (msgValid && msgData[15])); // R2
    end
  endgenerate

  assign selEntry = rteFlat[ptr*ENTRY_W +: ENTRY_W];

  // output slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValidQ <= 1'b0;
      msgAddrQ  <= '0;
      msgDataQ  <= '0;
    end else if (strobe.launch) begin
      msgValidQ <= 1'b1;
      msgAddrQ  <= msgAddrOf(selEntry);
      msgDataQ  <= msgDataOf(selEntry);
    end else if (msgReady) begin
      msgValidQ <= 1'b0;
    end
  end

  assign msgValid  = msgValidQ;
  assign msgAddr   = msgAddrQ;
  assign msgData   = msgDataQ;
  assign remoteIrr = remoteIrrQ;

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData))); // R9

endmodule

// File: rtl/irq_redir_control.sv
module irq_redir_control
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PTR_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] eligible,
  input  logic                msgValid,
  input  logic                msgReady,
  output ctlStrobe_t          strobe,
  output logic [PTR_W-1:0]    ptr
);

  localparam logic [PTR_W-1:0] LAST_PIN = PTR_W'(NUM_PINS - 1);

  logic [PTR_W-1:0] ptrQ;
  logic             slotFree;

  assign slotFree       = !msgValid || msgReady;
  assign strobe.advance = slotFree;
  assign strobe.launch  = slotFree && eligible[ptrQ];
  assign ptr            = ptrQ;

  always_ff @(posedge clk) begin
    if (!rstN)               ptrQ <= '0;
    else if (strobe.advance) ptrQ <= (ptrQ == LAST_PIN) ? '0 : ptrQ + 1'b1;
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ <= LAST_PIN); // R9
  AST_SCAN_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> $stable(ptrQ)); // R9

endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PINS-1:0]    irqPins,
  input  logic [NUM_PINS*64-1:0] rteFlat,
  input  logic                   eoiValid,
  input  logic [7:0]             eoiVector,
  output logic                   msgValid,
  input  logic                   msgReady,
  output logic [31:0]            msgAddr,
  output logic [31:0]            msgData,
  output logic [NUM_PINS-1:0]    remoteIrr
);

  localparam int PTR_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  ctlStrobe_t          strobe;
  logic [PTR_W-1:0]    ptr;
  logic [NUM_PINS-1:0] eligible;

  irq_redir_control #(.NUM_PINS(NUM_PINS), .PTR_W(PTR_W)) uCtl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .msgValid(msgValid),
    .msgReady(msgReady), .strobe(strobe), .ptr(ptr)
  );

  irq_redir_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES), .PTR_W(PTR_W)) uDp (
    .clk(clk), .rstN(rstN), .irqPins(irqPins), .rteFlat(rteFlat),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .msgReady(msgReady),
    .strobe(strobe), .ptr(ptr), .eligible(eligible), .msgValid(msgValid),
    .msgAddr(msgAddr), .msgData(msgData), .remoteIrr(remoteIrr)
  );

  initial begin
    AST_NO_EMPTY_BANK: assert (NUM_PINS >= 1 && SYNC_STAGES >= 1); // R1
  end

endmodule

// File: tb/tb_irq_redirect_engine.sv
module tb_irq_redirect_engine;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 24;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] pins = '0;
  logic [63:0] rte [N];
  logic [N*64-1:0] rteFlat;
  logic eoiValid = 1'b0;
  logic [7:0] eoiVector = '0;
  logic msgReady = 1'b1;
  logic msgValid;
  logic [31:0] msgAddr, msgData;
  logic [N-1:0] remoteIrr;

  int checks = 0;
  int errors = 0;
  int msgCount [256];
  logic [31:0] lastAddr [256];
  logic [31:0] lastData [256];

  // reference model state
  bit mS [SS][N];
  bit mPrev [N];
  bit mIrr [N];
  bit mRirr [N];
  int mPtr;
  bit mOutV;
  logic [31:0] mAddr, mData;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int p = 0; p < N; p++) rteFlat[p*64 +: 64] = rte[p];

  irq_redirect_engine #(.NUM_PINS(N), .SYNC_STAGES(SS)) dut (
    .clk(clk), .rstN(rstN), .irqPins(pins), .rteFlat(rteFlat),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .msgValid(msgValid),
    .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData), .remoteIrr(remoteIrr)
  );

  function automatic logic [63:0] mkEnt(input logic [7:0] vec, input logic [2:0] dm,
      input bit destMode, input bit level, input bit mask, input logic [15:0] dest);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = destMode; e[15] = level; e[16] = mask;
    e[63:48] = dest;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model and acceptance capture, both on pre-edge values
  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < N; p++) begin
        for (int k = 0; k < SS; k++) mS[k][p] = 0;
        mPrev[p] = 0; mIrr[p] = 0; mRirr[p] = 0;
      end
      mPtr = 0; mOutV = 0; mAddr = '0; mData = '0;
    end else begin
      bit slotFree, launch;
      int oldPtr;
      logic [63:0] e;
      if (msgValid && msgReady) begin
        msgCount[msgData[7:0]]++;
        lastAddr[msgData[7:0]] = msgAddr;
        lastData[msgData[7:0]] = msgData;
      end
      slotFree = !mOutV || msgReady;
      oldPtr = mPtr;
      e = rte[oldPtr];
      launch = slotFree && mIrr[oldPtr] && !e[16] && (!e[15] || !mRirr[oldPtr]);
      for (int p = 0; p < N; p++) begin
        bit rise;
        logic [63:0] en;
        en = rte[p];
        rise = mS[SS-1][p] && !mPrev[p];
        if (en[15]) mIrr[p] = mS[SS-1][p];
        else if (rise && !en[16]) mIrr[p] = 1;
        else if (launch && p == oldPtr) mIrr[p] = 0;
        if (!en[15]) mRirr[p] = 0;
        else if (eoiValid && mRirr[p] && en[7:0] == eoiVector) mRirr[p] = 0;
        else if (launch && p == oldPtr) mRirr[p] = 1;
        mPrev[p] = mS[SS-1][p];
        for (int k = SS-1; k > 0; k--) mS[k][p] = mS[k-1][p];
        mS[0][p] = pins[p];
      end
      if (launch) begin
        mOutV = 1;
        mAddr = 32'hFEE0_0000 | (32'(e[63:48]) << 4) | (32'(e[11]) << 2);
        mData = 32'(e[7:0]) | (32'(e[10:8]) << 8) | (32'(e[15]) << 15);
      end else if (msgReady) mOutV = 0;
      if (slotFree) mPtr = (mPtr == N-1) ? 0 : mPtr + 1;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check(msgValid == mOutV, "R9 valid", 32'(msgValid), 32'(mOutV));
      if (mOutV) begin
        check(msgAddr == mAddr, "R7 addr", msgAddr, mAddr);
        check(msgData == mData, "R8 data", msgData, mData);
      end
      for (int p = 0; p < N; p++)
        if (remoteIrr[p] != mRirr[p])
          check(0, "R6 remoteIrr", 32'(remoteIrr), 32'(p));
      checks++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clearCounts();
    for (int v = 0; v < 256; v++) msgCount[v] = 0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoiValid = 1'b1; eoiVector = v;
    tick(1);
    eoiValid = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < N; p++) rte[p] = mkEnt(8'(8'h20 + p), 3'd0, 0, 0, 1, 16'h0);
    clearCounts();
    tick(3);
    // R1: reset state
    check(msgValid == 1'b0, "R1 valid", 32'(msgValid), 32'h0);
    check(remoteIrr == '0, "R1 remoteIrr", 32'(remoteIrr), 32'h0);
    rstN = 1'b1;
    tick(2);

    // R4 R7 R8: one edge gives one message with exact fields
    rte[2] = mkEnt(8'h32, 3'd1, 1, 0, 0, 16'h00AB);
    pins[2] = 1'b1; tick(2); pins[2] = 1'b0;
    tick(40);
    check(msgCount[8'h32] == 1, "R4 edge count", 32'(msgCount[8'h32]), 32'd1);
    check(lastAddr[8'h32] == 32'hFEE00AB4, "R7 addr", lastAddr[8'h32], 32'hFEE00AB4);
    check(lastData[8'h32] == 32'h00000132, "R8 data", lastData[8'h32], 32'h00000132);

    // R3: masked edge discarded, unmasking does not revive it
    rte[5] = mkEnt(8'h35, 3'd0, 0, 0, 1, 16'h0005);
    pins[5] = 1'b1; tick(3); pins[5] = 1'b0; tick(5);
    rte[5][16] = 1'b0;
    tick(40);
    check(msgCount[8'h35] == 0, "R3 masked edge", 32'(msgCount[8'h35]), 32'd0);

    // R2 R5: level pin fires once then coalesces
    rte[7] = mkEnt(8'h41, 3'd0, 0, 1, 0, 16'h0007);
    pins[7] = 1'b1; tick(40);
    check(msgCount[8'h41] == 1, "R2 level once", 32'(msgCount[8'h41]), 32'd1);
    check(remoteIrr[7] == 1'b1, "R2 remoteIrr set", 32'(remoteIrr[7]), 32'd1);
    tick(60);
    check(msgCount[8'h41] == 1, "R5 coalesce", 32'(msgCount[8'h41]), 32'd1);

    // R6: non-matching EOI has no effect, matching EOI refires
    eoi(8'h99); tick(40);
    check(remoteIrr[7] == 1'b1, "R6 other vector", 32'(remoteIrr[7]), 32'd1);
    check(msgCount[8'h41] == 1, "R6 other vector count", 32'(msgCount[8'h41]), 32'd1);
    eoi(8'h41); tick(40);
    check(msgCount[8'h41] == 2, "R6 refire", 32'(msgCount[8'h41]), 32'd2);
    pins[7] = 1'b0; tick(4);
    eoi(8'h41); tick(40);
    check(remoteIrr[7] == 1'b0, "R6 clear", 32'(remoteIrr[7]), 32'd0);
    check(msgCount[8'h41] == 2, "R6 no refire when low", 32'(msgCount[8'h41]), 32'd2);

    // R10: switching to edge mode drops remote IRR
    pins[7] = 1'b1; tick(40);
    check(remoteIrr[7] == 1'b1, "R10 precondition", 32'(remoteIrr[7]), 32'd1);
    rte[7][15] = 1'b0; rte[7][14] = 1'b1; tick(1);
    check(remoteIrr[7] == 1'b0, "R10 edge clears", 32'(remoteIrr[7]), 32'd0);
    pins[7] = 1'b0; tick(40);

    // R11: masked level keeps request, fires after unmask
    rte[9] = mkEnt(8'h49, 3'd2, 0, 1, 1, 16'h0009);
    pins[9] = 1'b1; tick(40);
    check(msgCount[8'h49] == 0, "R11 masked", 32'(msgCount[8'h49]), 32'd0);
    rte[9][16] = 1'b0; tick(40);
    check(msgCount[8'h49] == 1, "R11 unmasked", 32'(msgCount[8'h49]), 32'd1);
    pins[9] = 1'b0; tick(4); eoi(8'h49);

    // R9: backpressure with several edge requests pending
    for (int p = 10; p < 14; p++) rte[p] = mkEnt(8'(8'h50 + p), 3'd0, 0, 0, 0, 16'(p));
    msgReady = 1'b0;
    pins[13:10] = 4'hF; tick(3); pins[13:10] = 4'h0;
    tick(50);
    check(msgValid == 1'b1, "R9 held", 32'(msgValid), 32'd1);
    msgReady = 1'b1; tick(60);
    for (int p = 10; p < 14; p++)
      check(msgCount[8'h50 + p] == 1, "R9 all delivered", 32'(msgCount[8'h50 + p]), 32'd1);

    // mixed random phase: EOI/launch and edge/launch collisions
    for (int p = 0; p < N; p++)
      rte[p] = mkEnt(8'(8'h60 + (p % 6)), 3'(p), 1'(p), 1'(p % 3 == 0), 0, 16'(p * 37));
    for (int i = 0; i < 4000; i++) begin
      pins = N'($urandom) & N'($urandom);
      msgReady = ($urandom % 4) != 0;
      eoiValid = ($urandom % 3) == 0;
      eoiVector = 8'(8'h60 + ($urandom % 6));
      if (($urandom % 200) == 0) begin
        int q;
        q = $urandom % N;
        rte[q][16] = ~rte[q][16];
      end
      tick(1);
    end
    eoiValid = 1'b0; msgReady = 1'b1; pins = '0;
    tick(50);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule